// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block is the shared receive store of a sixteen-line serial multiplexer. When any line's receiver finishes a character, it offers that character here along with its line number and any parity or framing fault. All lines feed one first-in first-out silo. Software sees the silo through a single receive word. Every read of that word takes one entry, so characters from all lines come out in the order they arrived. Software keeps reading while bit 15 of the word is set, which means while the word is negative as a signed 16-bit value.

Interrupts are paced by a programmable alarm level. The receive flag rises once the silo holds at least the alarm number of entries. A receive interrupt is requested while that flag is up and the software enable is on. A write to the control word with the master-clear bit set returns the silo to its empty, quiet state.

Top module: `rx_silo`

## Requirements
- R1: `rd_word[15]` is 1 exactly when the silo holds at least one entry. While the silo is empty, `rd_word` is all zeros.
- R2: The head entry is packed into `rd_word` as follows: bits 7:0 hold the character, bits 11:8 the line number, bit 12 the parity fault, bit 13 the framing fault (break) and bit 14 the overrun mark.
- R3: Entries leave in arrival order. A cycle with `rd_en` high removes exactly one entry. `rd_en` on an empty silo changes nothing.
- R4: The silo holds 64 entries. A push into a full silo in a cycle with no removal is discarded, and the stored entries are unchanged.
- R5: After one or more discarded pushes, the next entry that is stored carries bit 14 set. Entries stored after it carry bit 14 clear until another push is discarded.
- R6: When the silo is full, a push and a removal in the same cycle both take effect, and the silo stays full.
- R7: `rx_flag` (the status bit at position 7) is 1 when the fill level is nonzero and at least the alarm level. With an alarm level of 0, any nonzero fill raises it. The alarm level is written through `alarm_wr`/`alarm_wdata`.
- R8: `rx_irq` equals `rx_flag` AND the receive enable. The enable is loaded from bit 6 of `ctl_wdata` on every `ctl_wr`.
- R9: A `ctl_wr` with bit 11 set (master clear) empties the silo, sets the alarm level and the enable to 0, and drops any pending overrun mark. It overrides a push, a read or an alarm write in the same cycle.
- R10: After `rst`, the block is in the same state as after a master clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | A receiver offers a character this cycle |
| push_line | input | 4 | Number of the line offering the character |
| push_char | input | 8 | Received character |
| push_perr | input | 1 | Parity fault on this character |
| push_ferr | input | 1 | Framing fault (break) on this character |
| rd_en | input | 1 | Read strobe of the receive word; removes the head entry |
| rd_word | output | 16 | Packed head entry with the present bit |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control data: bit 11 master clear, bit 6 receive enable |
| alarm_wr | input | 1 | Alarm level write strobe |
| alarm_wdata | input | 7 | New alarm level, 0 to 64 |
| rx_flag | output | 1 | Receive status flag (control bit 7) |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The functions that collide are a push and a removal in the same cycle. They matter most when the silo is full, where the removal makes room for the push. They also matter right after a discarded push, where the overrun mark must land on the stored entry and not on the one being read. The bench fills the silo to 64, keeps pushing to force discards, then issues push and read together. It also fires a master clear in the same cycle as a push and an alarm write. A behavioural queue model predicts the word, flag and interrupt for every cycle, and any mismatch against the model is reported.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int CHAR_W        = 8;
    localparam int LINE_W        = 4;
    localparam int WORD_W        = 16;
    localparam int CTL_MCLR_BIT  = 11;
    localparam int CTL_RIE_BIT   = 6;

    // Field order matters: packed under the present bit it yields the
    // receive word layout (ovr 14, ferr 13, perr 12, line 11:8, char 7:0).
    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_entry_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic present,
                                                    input silo_entry_t e);
        return present ? {1'b1, e} : '0;
    endfunction

endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push_req,
    input  silo_entry_t      push_data,
    input  logic             pop_req,
    output silo_entry_t      head,
    output logic [CNT_W-1:0] level
);

    silo_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             ovr_pend;
    logic             full, do_pop, do_push, dropped;
    silo_entry_t      store_val;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == CNT_W'(DEPTH));
    assign do_pop  = pop_req && (level != '0) && !clr;
    assign do_push = push_req && !clr && (!full || do_pop);
    assign dropped = push_req && !clr && full && !do_pop;

    always_comb begin
        store_val     = push_data;
        store_val.ovr = ovr_pend;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= store_val;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (dropped)      ovr_pend <= 1'b1;
            else if (do_push) ovr_pend <= 1'b0;
        end
    end

    assign head = mem[rd_ptr];

    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));
    a_r3_single_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_req && level != '0 && !push_req && !clr) |=> level == $past(level) - 1'b1);
    a_r5_mark_consumed: assert property (@(posedge clk) disable iff (rst)
        (ovr_pend && push_req && !clr && level != CNT_W'(DEPTH)) |=> !ovr_pend);
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level == '0 && !ovr_pend));

endmodule

// File: rtl/rxs_alarm.sv
module rxs_alarm #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ctl_wr,
    input  logic             en_bit,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] alarm_wdata,
    input  logic [CNT_W-1:0] level,
    output logic             flag,
    output logic             irq
);

    logic [CNT_W-1:0] alarm_lvl;
    logic             rie;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            alarm_lvl <= '0;
            rie       <= 1'b0;
        end else begin
            if (alarm_wr) alarm_lvl <= alarm_wdata;
            if (ctl_wr)   rie       <= en_bit;
        end
    end

    assign flag = (level != '0) && (level >= alarm_lvl);
    assign irq  = flag && rie;

    a_r9_alarm_reset: assert property (@(posedge clk) disable iff (rst)
        clr |=> (alarm_lvl == '0 && !rie));
    a_r8_enable_load: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !clr) |=> rie == $past(en_bit));

endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push_en,
    input  logic [LINE_W-1:0]   push_line,
    input  logic [CHAR_W-1:0]   push_char,
    input  logic                push_perr,
    input  logic                push_ferr,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_word,
    input  logic                ctl_wr,
    input  logic [WORD_W-1:0]   ctl_wdata,
    input  logic                alarm_wr,
    input  logic [CNT_W-1:0]    alarm_wdata,
    output logic                rx_flag,
    output logic                rx_irq
);

    logic             mclr;
    silo_entry_t      in_entry, head;
    logic [CNT_W-1:0] level;

    assign mclr = ctl_wr && ctl_wdata[CTL_MCLR_BIT];

    always_comb begin
        in_entry      = '0;
        in_entry.ch   = push_char;
        in_entry.line = push_line;
        in_entry.perr = push_perr;
        in_entry.ferr = push_ferr;
    end

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (mclr),
        .push_req  (push_en),
        .push_data (in_entry),
        .pop_req   (rd_en),
        .head      (head),
        .level     (level)
    );

    rxs_alarm #(.CNT_W(CNT_W)) u_alarm (
        .clk         (clk),
        .rst         (rst),
        .clr         (mclr),
        .ctl_wr      (ctl_wr),
        .en_bit      (ctl_wdata[CTL_RIE_BIT]),
        .alarm_wr    (alarm_wr),
        .alarm_wdata (alarm_wdata),
        .level       (level),
        .flag        (rx_flag),
        .irq         (rx_irq)
    );

    assign rd_word = pack_word(level != '0, head);

    a_r1_flag_implies_present: assert property (@(posedge clk) disable iff (rst)
        rx_flag |-> rd_word[15]);
    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (rd_word == '0 && !rx_irq && !rx_flag));
    a_r8_irq_tracks_flag: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_wdata[CTL_MCLR_BIT] && ctl_wdata[CTL_RIE_BIT]) |=> rx_irq == rx_flag);

endmodule

// File: tb/test_rx_silo.sv
`timescale 1ns/1ps
module test_rx_silo;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_en = 0, push_perr = 0, push_ferr = 0, rd_en = 0;
    logic [3:0]  push_line = 0;
    logic [7:0]  push_char = 0;
    logic        ctl_wr = 0, alarm_wr = 0;
    logic [15:0] ctl_wdata = 0;
    logic [6:0]  alarm_wdata = 0;
    logic [15:0] rd_word;
    logic        rx_flag, rx_irq;

    int    checks = 0, errors = 0;
    string cur_req = "R10";
    bit    done = 0;

    int q[$];
    int m_alarm = 0;
    bit m_en = 0, m_pend = 0;

    always #2 clk = ~clk;

    rx_silo i_rx_silo (
        .clk(clk), .rst(rst), .push_en(push_en), .push_line(push_line),
        .push_char(push_char), .push_perr(push_perr), .push_ferr(push_ferr),
        .rd_en(rd_en), .rd_word(rd_word), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata),
        .rx_flag(rx_flag), .rx_irq(rx_irq)
    );

    task automatic compare();
        logic [15:0] ew;
        logic ef, ei;
        ew = (q.size() > 0) ? (16'h8000 | 16'(q[0])) : 16'h0;
        ef = (q.size() > 0) && (q.size() >= m_alarm);
        ei = ef && m_en;
        checks++;
        if (rd_word !== ew || rx_flag !== ef || rx_irq !== ei) begin
            errors++;
            $display("FAIL %s: word=%h flag=%b irq=%b expected word=%h flag=%b irq=%b",
                     cur_req, rd_word, rx_flag, rx_irq, ew, ef, ei);
        end
    endtask

    // One clock: check current outputs, drive inputs, advance the model.
    task automatic cyc(input bit p, input int ln, input int ch, input bit pe, input bit fe,
                       input bit r, input bit cw, input int cd, input bit aw, input int ad);
        bit pop, acc, full;
        @(negedge clk);
        compare();
        push_en = p; push_line = 4'(ln); push_char = 8'(ch);
        push_perr = pe; push_ferr = fe; rd_en = r;
        ctl_wr = cw; ctl_wdata = 16'(cd); alarm_wr = aw; alarm_wdata = 7'(ad);
        if (cw && cd[11]) begin
            q.delete(); m_alarm = 0; m_en = 0; m_pend = 0;
        end else begin
            pop  = r && q.size() > 0;
            full = q.size() == DEPTH;
            acc  = p && (!full || pop);
            if (pop) void'(q.pop_front());
            if (acc) begin
                q.push_back((ch & 8'hff) | ((ln & 15) << 8) | (int'(pe) << 12)
                            | (int'(fe) << 13) | (int'(m_pend) << 14));
                m_pend = 0;
            end else if (p) m_pend = 1;
            if (cw) m_en = cd[6];
            if (aw) m_alarm = ad;
        end
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,0,0,0); endtask
    task automatic push(input int ln, input int ch, input bit pe, input bit fe);
        cyc(1,ln,ch,pe,fe,0,0,0,0,0);
    endtask
    task automatic rd(); cyc(0,0,0,0,0,1,0,0,0,0); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        cur_req = "R10"; idle(); idle();

        cur_req = "R2";
        push(3, 8'h41, 0, 0); push(15, 8'hFF, 1, 0); push(0, 8'h00, 0, 1); push(9, 8'h5a, 1, 1);
        cur_req = "R1";
        repeat (5) rd();

        cur_req = "R3";
        push(1, 8'h11, 0, 0); push(2, 8'h22, 0, 0);
        cyc(1,4,8'h44,0,0,1,0,0,0,0); rd(); rd(); rd(); rd(); idle();

        cur_req = "R7";
        push(5, 1, 0, 0); idle();
        cyc(0,0,0,0,0,0,0,0,1,3); push(5, 2, 0, 0); idle(); push(5, 3, 0, 0); idle();
        cyc(0,0,0,0,0,0,0,0,1,5); idle(); push(6, 4, 0, 0); push(6, 5, 0, 0); idle();

        cur_req = "R8";
        cyc(0,0,0,0,0,0,1,16'h0040,0,0); idle(); rd(); idle();
        cyc(0,0,0,0,0,0,1,16'h0000,0,0); idle();
        cyc(0,0,0,0,0,0,1,16'h0040,1,0); idle();
        repeat (5) rd();

        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++) push(i % 16, i, 0, 0);
        idle(); push(7, 8'hEE, 0, 0); push(8, 8'hEF, 1, 0); idle();
        cur_req = "R6";
        cyc(1,10,8'hA0,0,0,1,0,0,0,0); idle(); cyc(1,11,8'hA1,0,0,1,0,0,0,0);
        cur_req = "R5";
        push(12, 8'hB0, 0, 0); rd(); push(13, 8'hB1, 0, 0); push(13, 8'hB2, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) rd();

        cur_req = "R9";
        push(1, 1, 0, 0); push(2, 2, 0, 0);
        cyc(0,0,0,0,0,0,1,16'h0040,1,1); idle();
        cyc(1,3,3,0,0,1,1,16'h0840,1,4); idle(); idle();
        push(4, 4, 0, 0); idle(); rd(); idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule